// File: doc/BRIEF.md
# Three-Phase Dead-Time Gate Controller

This block sits between a PWM source and the gate pre-drivers of a three-phase bridge. Each phase has a high-side command and a low-side command. The block turns each pair into two registered gate enables that are never on together. Before either switch of a phase turns on, the opposite switch must have been off for a programmed dead time. The dead time comes from a 2-bit code held in a small configuration register. The count runs on the 10 MHz core clock, so each code gives a whole number of clock cycles.

A shutdown input clears all six enables at once, through combinational gating, without waiting for a clock edge. While shutdown is high the dead-time counters are held at zero. After release, no switch turns on until one full dead-time interval has passed. When both commands of a phase are high together, that is an illegal request, and the phase keeps both switches off.

Top module: `tri_deadtime_ctrl`

## Requirements
- R1: In every phase the high-side and low-side enables are never 1 in the same cycle.
- R2: The dead-time code sets the gap in 10 MHz clock cycles: code 3 gives 6 cycles, code 2 gives 11, code 1 gives 16 and code 0 gives 21.
- R3: A turn-on follows the opposite switch's turn-off by exactly the dead time.
  - When the active command swaps to the other side, the old enable drops at the next clock edge.
  - The new enable then rises after exactly the dead time, counted in cycles with both enables low.
  - A command that is already allowed drives its enable at the next edge.
- R4: Reset sets the code register to 0. The first turn-on after reset therefore waits 21 cycles.
- R5: When both commands of a phase are 1, both enables of that phase are 0 from the next edge on.
- R6: While shutdown is 1, all six enables are 0 in the same cycle, before any clock edge.
- R7: After shutdown falls, each phase keeps both enables low for a full dead-time interval before it turns one on.
- R8: A write of a new code never changes an interval already in progress.
  - The code is captured when an interval starts: whenever an enable is on, and while shutdown is high.
  - A write made during an interval changes only the next one.
- R9: During reset all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 10 MHz by default |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn | input | 1 | Fault shutdown; forces all enables off |
| cfg_wr | input | 1 | Write strobe for the dead-time code |
| cfg_code | input | 2 | New dead-time code, captured when cfg_wr is 1 |
| hs_cmd | input | NPH | High-side turn-on request, one bit per phase |
| ls_cmd | input | NPH | Low-side turn-on request, one bit per phase |
| hs_en | output | NPH | High-side gate enable, one bit per phase |
| ls_en | output | NPH | Low-side gate enable, one bit per phase |

## Verification
The assertions assume the following about the inputs:
- The commands, shutdown and the configuration strobe change only between clock edges.
- A shutdown may arrive at any point in a cycle.

The stimulus meets this by driving every input at the falling edge, including the random sections where the commands, shutdown and code writes overlap. The properties are written so that they also hold when both commands of a phase are high. The bench therefore drives that case on purpose, both in a directed test and at random.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   // Dead time in tenths of a microsecond for a 2-bit code: 21, 16, 11, 6
   function automatic int dead_tenths(input logic [1:0] code);
      return 21 - 5 * int'(code);
   endfunction

   // Dead time in clock cycles for a clock given in MHz
   function automatic int dead_cycles(input logic [1:0] code, input int clk_mhz);
      return (dead_tenths(code) * clk_mhz) / 10;
   endfunction

endpackage

// File: rtl/dtc_cfg_reg.sv
module dtc_cfg_reg #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] code
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  code <= '0;
      else if (wr) code <= wdata;
   end

endmodule

// File: rtl/dtc_phase.sv
module dtc_phase #(
   parameter int CLK_MHZ = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shdn,
   input  logic       hi_cmd,
   input  logic       lo_cmd,
   input  logic [1:0] code,
   output logic       hi_q,
   output logic       lo_q
);

   localparam int MAXC = dtc_pkg::dead_cycles(2'b00, CLK_MHZ);
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] tgt;
   logic          hi_req, lo_req, gap_done;

   assign hi_req   = hi_cmd & ~lo_cmd;
   assign lo_req   = lo_cmd & ~hi_cmd;
   assign gap_done = (cnt == tgt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
         cnt  <= '0;
         tgt  <= CW'(MAXC);
      end else if (shdn) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
         cnt  <= '0;
         tgt  <= CW'(dtc_pkg::dead_cycles(code, CLK_MHZ));
      end else begin
         hi_q <= hi_req & (hi_q | (~lo_q & gap_done));
         lo_q <= lo_req & (lo_q | (~hi_q & gap_done));
         if (hi_q | lo_q) begin
            cnt <= CW'(1);
            tgt <= CW'(dtc_pkg::dead_cycles(code, CLK_MHZ));
         end else if (!gap_done) begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));

   // R3
   gap_before_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_q) || $rose(lo_q)) |-> $past(!hi_q && !lo_q));

   // R5
   both_cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cmd && lo_cmd) |=> (!hi_q && !lo_q));

   // R6
   shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shdn |=> (!hi_q && !lo_q));

   // R8
   tgt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_q && !lo_q && !shdn) |=> $stable(tgt));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= tgt);

endmodule

// File: rtl/tri_deadtime_ctrl.sv
module tri_deadtime_ctrl #(
   parameter int NPH     = 3,
   parameter int CLK_MHZ = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shdn,
   input  logic           cfg_wr,
   input  logic [1:0]     cfg_code,
   input  logic [NPH-1:0] hs_cmd,
   input  logic [NPH-1:0] ls_cmd,
   output logic [NPH-1:0] hs_en,
   output logic [NPH-1:0] ls_en
);

   localparam int CODE_W = 2;

   generate
      if (NPH < 1) begin : g_bad_nph
         $error("NPH must be at least 1");
      end
      if (CLK_MHZ < 10 || (CLK_MHZ % 10) != 0) begin : g_bad_clk
         $error("CLK_MHZ must be a positive multiple of 10");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic [NPH-1:0]    hi_q, lo_q;

   dtc_cfg_reg #(.CW(CODE_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .wdata (cfg_code),
      .code  (code)
   );

   generate
      for (genvar p = 0; p < NPH; p++) begin : g_ph
         dtc_phase #(.CLK_MHZ(CLK_MHZ)) u_ph (
            .clk    (clk),
            .rst_n  (rst_n),
            .shdn   (shdn),
            .hi_cmd (hs_cmd[p]),
            .lo_cmd (ls_cmd[p]),
            .code   (code),
            .hi_q   (hi_q[p]),
            .lo_q   (lo_q[p])
         );
      end
   endgenerate

   assign hs_en = hi_q & ~{NPH{shdn}};
   assign ls_en = lo_q & ~{NPH{shdn}};

   // R6
   shdn_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shdn) |-> (hs_en == '0 && ls_en == '0));

endmodule

// File: tb/tri_deadtime_ctrl_tb.sv
module tri_deadtime_ctrl_tb;

   localparam int  NPH    = 3;
   localparam time PERIOD = 100ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           shdn = 1'b0;
   logic           cfg_wr = 1'b0;
   logic [1:0]     cfg_code = 2'b00;
   logic [NPH-1:0] hs_cmd = '0;
   logic [NPH-1:0] ls_cmd = '0;
   logic [NPH-1:0] hs_en, ls_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(PERIOD/2) clk = ~clk;

   tri_deadtime_ctrl #(.NPH(NPH), .CLK_MHZ(10)) u_dut (
      .clk(clk), .rst_n(rst_n), .shdn(shdn), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
      .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .hs_en(hs_en), .ls_en(ls_en)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int gap_of(input int c);
      case (c)
         0: return 21;
         1: return 16;
         2: return 11;
         default: return 6;
      endcase
   endfunction

   // Behavioural reference
   bit m_hi[NPH];
   bit m_lo[NPH];
   int m_idle[NPH];
   int m_need[NPH];
   int m_code;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NPH; p++) begin
            m_hi[p] = 0; m_lo[p] = 0; m_idle[p] = 0; m_need[p] = 21;
         end
         m_code = 0;
      end else begin
         for (int p = 0; p < NPH; p++) begin
            bit want_hi, want_lo, nh, nl;
            want_hi = hs_cmd[p] && !ls_cmd[p];
            want_lo = ls_cmd[p] && !hs_cmd[p];
            if (shdn) begin
               nh = 0; nl = 0;
               m_idle[p] = 0;
               m_need[p] = gap_of(m_code);
            end else begin
               nh = want_hi && (m_hi[p] || (!m_lo[p] && m_idle[p] >= m_need[p]));
               nl = want_lo && (m_lo[p] || (!m_hi[p] && m_idle[p] >= m_need[p]));
               if (m_hi[p] || m_lo[p]) begin
                  m_idle[p] = 1;
                  m_need[p] = gap_of(m_code);
               end else if (m_idle[p] < m_need[p]) begin
                  m_idle[p]++;
               end
            end
            m_hi[p] = nh;
            m_lo[p] = nl;
         end
         if (cfg_wr) m_code = int'(cfg_code);
      end
   end

   // Compare on every clock
   always @(posedge clk) begin
      #2;
      for (int p = 0; p < NPH; p++) begin
         int e_hi, e_lo;
         e_hi = (m_hi[p] && !shdn) ? 1 : 0;
         e_lo = (m_lo[p] && !shdn) ? 1 : 0;
         if (!rst_n) begin
            // R9
            chk(!hs_en[p] && !ls_en[p], "R9 reset state", {hs_en[p], ls_en[p]}, 0);
         end else begin
            // R3 per-cycle agreement with the reference
            chk(hs_en[p] == e_hi[0] && ls_en[p] == e_lo[0], "R3 reference",
                {hs_en[p], ls_en[p]}, {e_hi[0], e_lo[0]});
            // R1
            chk(!(hs_en[p] && ls_en[p]), "R1 overlap", {hs_en[p], ls_en[p]}, 0);
         end
      end
   end

   task automatic write_code(input logic [1:0] c);
      @(negedge clk); cfg_wr = 1'b1; cfg_code = c;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   // Swap phase 0 to the other side and count cycles with both enables low
   task automatic swap(input bit to_hi, input int wr_at, input logic [1:0] wcode, output int gap);
      gap = 0;
      @(negedge clk); hs_cmd[0] = to_hi; ls_cmd[0] = !to_hi;
      for (int i = 0; i < 60; i++) begin
         @(posedge clk); #3;
         if (to_hi ? hs_en[0] : ls_en[0]) break;
         if (!hs_en[0] && !ls_en[0]) gap++;
         @(negedge clk); cfg_wr = (gap == wr_at); cfg_code = wcode;
      end
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic wait_on(input bit hi, output int gap);
      gap = 0;
      for (int i = 0; i < 60; i++) begin
         @(posedge clk); #3;
         if (hi ? hs_en[0] : ls_en[0]) break;
         gap++;
      end
   endtask

   initial begin
      int g;
      ls_cmd[0] = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4: code resets to 0, first turn-on waits 21 cycles
      wait_on(1'b0, g);
      chk(g == 21, "R4 first gap after reset", g, 21);
      repeat (3) @(negedge clk);

      // R3: swap with default code
      swap(1'b1, -1, 2'b00, g);
      chk(g == 21, "R3 swap gap code0", g, 21);
      repeat (2) @(negedge clk);

      // R8: a write in the middle of an interval does not change it
      swap(1'b0, 5, 2'b11, g);
      chk(g == 21, "R8 gap unchanged by mid-interval write", g, 21);
      repeat (2) @(negedge clk);
      swap(1'b1, -1, 2'b00, g);
      chk(g == 6, "R8 new code used next interval", g, 6);

      // R2: remaining codes
      write_code(2'b01);
      swap(1'b0, -1, 2'b00, g);
      chk(g == 16, "R2 code1", g, 16);
      write_code(2'b10);
      swap(1'b1, -1, 2'b00, g);
      chk(g == 11, "R2 code2", g, 11);
      write_code(2'b11);
      swap(1'b0, -1, 2'b00, g);
      chk(g == 6, "R2 code3", g, 6);

      // R5: both commands on phase 1
      @(negedge clk); hs_cmd[1] = 1'b1; ls_cmd[1] = 1'b0;
      repeat (10) @(negedge clk);
      hs_cmd[1] = 1'b1; ls_cmd[1] = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk); #3;
         chk(!hs_en[1] && !ls_en[1], "R5 both commands", {hs_en[1], ls_en[1]}, 0);
      end
      @(negedge clk); hs_cmd[1] = 1'b0; ls_cmd[1] = 1'b0;

      // R6: shutdown clears outputs before the next edge
      @(negedge clk); ls_cmd[0] = 1'b0; hs_cmd[0] = 1'b1;
      repeat (12) @(negedge clk);
      chk(hs_en[0] == 1'b1, "R6 precondition on", hs_en[0], 1);
      shdn = 1'b1;
      #1;
      chk(hs_en == '0 && ls_en == '0, "R6 immediate off", {hs_en, ls_en}, 0);
      repeat (4) @(negedge clk);
      // R7: full interval (code 3) after release
      shdn = 1'b0;
      wait_on(1'b1, g);
      chk(g == 6, "R7 gap after release", g, 6);

      // Random mix on all phases
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 7) == 0) begin
            hs_cmd = NPH'($urandom);
            ls_cmd = NPH'($urandom) & ~(($urandom_range(0, 3) == 0) ? '0 : hs_cmd);
         end
         shdn     = ($urandom_range(0, 150) == 0);
         cfg_wr   = ($urandom_range(0, 60) == 0);
         cfg_code = 2'($urandom);
      end
      @(negedge clk); shdn = 1'b0; cfg_wr = 1'b0; hs_cmd = '0; ls_cmd = '0;
      repeat (30) @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule